// File: doc/BRIEF.md
# Windowed Display Raster Compositor

This block generates a progressive output raster, 1280x1024 active by default, with blanking and sync widths set by parameters. It places an unscaled camera image in the top-left corner of the screen. Only the pixels inside that window are fetched from a frame buffer, and every other active pixel is driven as black.

The block issues a read request and a linear address for each window pixel. Returned data arrives a fixed, parameterised number of cycles later. Data-enable and both syncs are delayed by the same amount, plus one output register, so they stay aligned with the pixel they frame. Every frame starts reading at address zero of whichever bank the buffer controller has selected. A one-cycle pulse on the first cycle after the last active line tells that controller the whole frame has been read and the banks may be swapped.

Top module: `raster_compositor`

## Requirements
- R1: While reset is held, and for the first RD_LAT+1 cycles after its release, pixOut, deOut, hsyncOut and vsyncOut are 0. During reset hCount and vCount are 0, and frameDone is 0.
- R2: After reset, hCount advances by one each clock and wraps from H_TOTAL-1 to 0. vCount advances by one on each wrap of hCount and wraps from V_TOTAL-1 to 0.
- R3: deOut is high exactly when the raster position RD_LAT+1 cycles earlier had hCount < H_ACTIVE and vCount < V_ACTIVE.
- R4: hsyncOut is high (positive polarity) exactly when the position RD_LAT+1 cycles earlier had hCount in [H_ACTIVE+H_FP, H_ACTIVE+H_FP+H_SYNC). vsyncOut is defined the same way on vCount with V_ACTIVE, V_FP and V_SYNC.
- R5: rdReq is high exactly when hCount < WIN_W and vCount < WIN_H.
- R6: While rdReq is high, rdAddr equals vCount*WIN_W + hCount, so every frame's first request uses address 0. The cycle after frameDone, rdAddr is 0.
- R7: When the position RD_LAT+1 cycles earlier was inside the window, pixOut equals the rdData value present RD_LAT cycles after that request.
- R8: When deOut is high and the position was outside the window, pixOut is 0 (black), whatever rdData carries.
- R9: When deOut is low (blanking), pixOut is 0.
- R10: frameDone is high for exactly one clock per frame, in the cycle where hCount is 0 and vCount equals V_ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdData | input | PIX_W | Pixel data returned by the frame buffer RD_LAT cycles after a request |
| rdReq | output | 1 | Read request for the current window pixel |
| rdAddr | output | AW | Linear pixel address within the read bank |
| pixOut | output | PIX_W | Output pixel, black outside the window and in blanking |
| deOut | output | 1 | Data enable aligned with pixOut |
| hsyncOut | output | 1 | Horizontal sync aligned with pixOut |
| vsyncOut | output | 1 | Vertical sync aligned with pixOut |
| frameDone | output | 1 | One-cycle pulse once all active lines of a frame have been read |
| hCount | output | HW | Horizontal raster position (request side) |
| vCount | output | VW | Vertical raster position (request side) |

## Verification
The bound checker watches, on every cycle, the following properties: the stepping and wrap of the horizontal counter, requests confined to the window, unit address steps along a window line, the address reset after frameDone, the single-cycle width of frameDone, and zero pixels whenever data-enable is low. The bench checks what only a timed model can show. That includes sync and data-enable placement after the pipeline delay, the match between returned data and the right window pixel, black fill when the memory returns garbage outside the window, and clean recovery from a reset asserted mid-frame.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // Strobes passed from the raster control to the datapath.
  typedef struct packed {
    logic active;    // inside the active area
    logic inWin;     // inside the camera window
    logic hSync;
    logic vSync;
    logic frameEnd;  // first cycle after the last active line
    logic vActive;   // current line is an active line
  } rasterStrobe_t;

  // One stage of the delay line that tracks the memory latency.
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
    logic win;
  } tapStage_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int H_ACTIVE = 1280,
  parameter int H_FP     = 48,
  parameter int H_SYNC   = 112,
  parameter int H_BP     = 248,
  parameter int V_ACTIVE = 1024,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 3,
  parameter int V_BP     = 38,
  parameter int WIN_W    = 640,
  parameter int WIN_H    = 480,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output rasterStrobe_t strobe
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam int HS_START = H_ACTIVE + H_FP;
  localparam int HS_END   = HS_START + H_SYNC;
  localparam int VS_START = V_ACTIVE + V_FP;
  localparam int VS_END   = VS_START + V_SYNC;

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hCnt == H_LAST) begin
      hCnt <= '0;
      vCnt <= (vCnt == V_LAST) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  logic hAct, vAct;

  always_comb begin
    hAct            = int'(hCnt) < H_ACTIVE;
    vAct            = int'(vCnt) < V_ACTIVE;
    strobe.active   = hAct && vAct;
    strobe.inWin    = (int'(hCnt) < WIN_W) && (int'(vCnt) < WIN_H);
    strobe.hSync    = (int'(hCnt) >= HS_START) && (int'(hCnt) < HS_END);
    strobe.vSync    = (int'(vCnt) >= VS_START) && (int'(vCnt) < VS_END);
    strobe.frameEnd = (hCnt == '0) && (int'(vCnt) == V_ACTIVE);
    strobe.vActive  = vAct;
  end

  assign hCount = hCnt;
  assign vCount = vCnt;
endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int RD_LAT = 2,
  parameter int WIN_W  = 640,
  parameter int WIN_H  = 480,
  localparam int AW    = $clog2(WIN_W * WIN_H + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rasterStrobe_t    strobe,
  input  logic [PIX_W-1:0] rdData,
  output logic             rdReq,
  output logic [AW-1:0]    rdAddr,
  output logic [PIX_W-1:0] pixOut,
  output logic             deOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             frameDone
);
  logic [AW-1:0] addrCnt;

  assign rdReq     = strobe.active && strobe.inWin;
  assign rdAddr    = addrCnt;
  assign frameDone = strobe.frameEnd;

  // Linear address: advances on each request, cleared on every blank line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               addrCnt <= '0;
    else if (!strobe.vActive) addrCnt <= '0;
    else if (rdReq)           addrCnt <= addrCnt + 1'b1;
  end

  tapStage_t tapIn;
  assign tapIn = '{de: strobe.active, hs: strobe.hSync, vs: strobe.vSync, win: rdReq};

  for (genvar g = 0; g < RD_LAT; g++) begin : gen_tap
    tapStage_t q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= tapIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= gen_tap[g-1].q;
      end
    end
  end

  tapStage_t tapOut;
  assign tapOut = gen_tap[RD_LAT-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixOut   <= '0;
      deOut    <= 1'b0;
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
    end else begin
      pixOut   <= tapOut.win ? rdData : '0;
      deOut    <= tapOut.de;
      hsyncOut <= tapOut.hs;
      vsyncOut <= tapOut.vs;
    end
  end
endmodule

// File: rtl/raster_compositor.sv
module raster_compositor
  import raster_pkg::*;
#(
  parameter int H_ACTIVE = 1280,
  parameter int H_FP     = 48,
  parameter int H_SYNC   = 112,
  parameter int H_BP     = 248,
  parameter int V_ACTIVE = 1024,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 3,
  parameter int V_BP     = 38,
  parameter int WIN_W    = 640,
  parameter int WIN_H    = 480,
  parameter int PIX_W    = 24,
  parameter int RD_LAT   = 2,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL),
  localparam int AW      = $clog2(WIN_W * WIN_H + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] rdData,
  output logic             rdReq,
  output logic [AW-1:0]    rdAddr,
  output logic [PIX_W-1:0] pixOut,
  output logic             deOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             frameDone,
  output logic [HW-1:0]    hCount,
  output logic [VW-1:0]    vCount
);
  rasterStrobe_t strobe;

  raster_ctrl #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .WIN_W(WIN_W), .WIN_H(WIN_H)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .hCount(hCount), .vCount(vCount), .strobe(strobe)
  );

  raster_datapath #(
    .PIX_W(PIX_W), .RD_LAT(RD_LAT), .WIN_W(WIN_W), .WIN_H(WIN_H)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdData(rdData),
    .rdReq(rdReq), .rdAddr(rdAddr), .pixOut(pixOut), .deOut(deOut),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .frameDone(frameDone)
  );
endmodule

// File: rtl/raster_compositor_checker.sv
module raster_compositor_checker #(
  parameter int H_TOTAL = 1688,
  parameter int WIN_W   = 640,
  parameter int WIN_H   = 480,
  parameter int PIX_W   = 24,
  parameter int HW      = 11,
  parameter int VW      = 11,
  parameter int AW      = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdReq,
  input logic [AW-1:0]    rdAddr,
  input logic [PIX_W-1:0] pixOut,
  input logic             deOut,
  input logic             frameDone,
  input logic [HW-1:0]    hCount,
  input logic [VW-1:0]    vCount
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

  assert_hcount_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hCount == H_LAST) |=> (hCount == '0));

  assert_hcount_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hCount != H_LAST) |=> (hCount == $past(hCount) + 1'b1));

  assert_req_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdReq |-> ((int'(hCount) < WIN_W) && (int'(vCount) < WIN_H)));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && $past(rdReq) && (hCount != '0)) |-> (rdAddr == $past(rdAddr) + 1'b1));

  assert_addr_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> (rdAddr == '0));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  assert_blank_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !deOut |-> (pixOut == '0));
endmodule

bind raster_compositor raster_compositor_checker #(
  .H_TOTAL(H_TOTAL), .WIN_W(WIN_W), .WIN_H(WIN_H), .PIX_W(PIX_W),
  .HW(HW), .VW(VW), .AW(AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rdReq(rdReq), .rdAddr(rdAddr), .pixOut(pixOut),
  .deOut(deOut), .frameDone(frameDone), .hCount(hCount), .vCount(vCount)
);

// File: tb/raster_compositor_tb_top.sv
module raster_compositor_tb_top;
  localparam int HA = 16, HFP = 2, HSY = 3, HBP = 3;
  localparam int VA = 12, VFP = 1, VSY = 2, VBP = 2;
  localparam int WW = 6, WH = 5, PW = 24, LAT = 3;
  localparam int HT = HA + HFP + HSY + HBP;
  localparam int VT = VA + VFP + VSY + VBP;
  localparam int L  = LAT + 1;
  localparam int HW = $clog2(HT), VW = $clog2(VT), AW = $clog2(WW * WH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] rdData;
  logic rdReq, deOut, hsyncOut, vsyncOut, frameDone;
  logic [AW-1:0] rdAddr;
  logic [PW-1:0] pixOut;
  logic [HW-1:0] hCount;
  logic [VW-1:0] vCount;

  always #4 clk = ~clk;

  raster_compositor #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP),
    .WIN_W(WW), .WIN_H(WH), .PIX_W(PW), .RD_LAT(LAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rdData(rdData), .rdReq(rdReq), .rdAddr(rdAddr),
    .pixOut(pixOut), .deOut(deOut), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .frameDone(frameDone), .hCount(hCount), .vCount(vCount)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [PW-1:0] salt;

  function automatic logic [PW-1:0] memVal(int a);
    logic [PW-1:0] v;
    v = PW'(a * 32'h0000_A3C5) ^ salt;
    return v | {1'b1, {(PW-1){1'b0}}};
  endfunction

  // Frame buffer model: answers LAT cycles after each request, garbage otherwise.
  logic [PW-1:0] memPipe [LAT];
  always @(posedge clk) begin
    memPipe[0] <= rdReq ? memVal(int'(rdAddr)) : (PW'($urandom) | 1);
    for (int i = 1; i < LAT; i++) memPipe[i] <= memPipe[i-1];
  end
  assign rdData = memPipe[LAT-1];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkReset();
    check("R1 pix", 32'(pixOut), 0);
    check("R1 de", 32'(deOut), 0);
    check("R1 hsync", 32'(hsyncOut), 0);
    check("R1 vsync", 32'(vsyncOut), 0);
    check("R1 hCount", 32'(hCount), 0);
    check("R1 vCount", 32'(vCount), 0);
    check("R1 frameDone", 32'(frameDone), 0);
  endtask

  // n = cycles since reset release; compare all ports with the model.
  task automatic checkCycle(int n);
    int hn, vn, p, hp, vp;
    bit expReq, de, win;
    hn = n % HT;
    vn = (n / HT) % VT;
    check("R2 hCount", 32'(hCount), 32'(hn));
    check("R2 vCount", 32'(vCount), 32'(vn));
    expReq = (hn < WW) && (vn < WH);
    check("R5 rdReq", 32'(rdReq), 32'(expReq));
    if (expReq) check("R6 rdAddr", 32'(rdAddr), 32'(vn * WW + hn));
    check("R10 frameDone", 32'(frameDone), 32'((hn == 0) && (vn == VA)));
    p = n - L;
    if (p < 0) begin
      check("R1 de early", 32'(deOut), 0);
      check("R1 pix early", 32'(pixOut), 0);
      check("R1 sync early", 32'({hsyncOut, vsyncOut}), 0);
      return;
    end
    hp = p % HT;
    vp = (p / HT) % VT;
    de = (hp < HA) && (vp < VA);
    win = (hp < WW) && (vp < WH);
    check("R3 deOut", 32'(deOut), 32'(de));
    check("R4 hsyncOut", 32'(hsyncOut), 32'((hp >= HA + HFP) && (hp < HA + HFP + HSY)));
    check("R4 vsyncOut", 32'(vsyncOut), 32'((vp >= VA + VFP) && (vp < VA + VFP + VSY)));
    if (win)      check("R7 pixOut window", 32'(pixOut), 32'(memVal(vp * WW + hp)));
    else if (de)  check("R8 pixOut black", 32'(pixOut), 0);
    else          check("R9 pixOut blank", 32'(pixOut), 0);
  endtask

  task automatic runCycles(int count);
    checkCycle(0);
    for (int n = 1; n < count; n++) begin
      @(negedge clk);
      checkCycle(n);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int cut;
    void'($urandom(32'd20031105));
    salt = PW'($urandom);
    repeat (3) @(negedge clk);
    checkReset();                 // R1 while in reset
    rst_n = 1'b1;
    runCycles(3 * HT * VT + 5);   // R2..R10 over three frames
    // Directed corner: reset asserted at a random point mid-frame.
    cut = 50 + int'($urandom_range(0, HT * VT - 100));
    for (int i = 0; i < cut; i++) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    checkReset();                 // R1 after mid-frame reset
    salt = PW'($urandom);
    rst_n = 1'b1;
    runCycles(2 * HT * VT + 5);
    summary();
  end

  initial begin
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule